// File: doc/BRIEF.md
# Accumulator with Adder and Logic Unit

This block holds a 16-bit accumulator together with a one-bit extend register. A small adder and logic slice sits beside each accumulator bit. The surrounding control raises one operation strobe per cycle. On the next rising clock edge the accumulator and the extend bit take their new values. The operand word comes from a data register, and a byte-wide port feeds character input.

The block turns the strobes into three register controls. A load control takes the slice output, an increment control adds one, and a clear control forces zero. Both shifts rotate through the extend bit. The adder's carry-out is written into the extend bit. The block also drives three status flags, which the skip logic outside reads directly: accumulator zero, accumulator sign, and extend-bit zero.

Top module: `acc_alu`

## Requirements
- R1: An active-low asynchronous reset sets the accumulator and the extend bit to 0.
- R2: The AND strobe loads the bitwise AND of the accumulator and the operand. The extend bit keeps its value.
- R3: The ADD strobe loads the 16-bit sum of the accumulator and the operand, and the extend bit takes the carry-out of bit 15.
- R4: The operand-load strobe copies the operand into the accumulator. The extend bit keeps its value.
- R5: The byte-input strobe writes the input byte into accumulator bits 7..0. Bits 15..8 and the extend bit keep their values.
- R6: The complement strobe inverts every accumulator bit. The extend bit keeps its value.
- R7: The rotate-right strobe moves each accumulator bit down one position. Bit 15 takes the old extend bit, and the extend bit takes the old bit 0.
- R8: The rotate-left strobe moves each accumulator bit up one position. Bit 0 takes the old extend bit, and the extend bit takes the old bit 15.
- R9: The increment strobe adds one to the accumulator, wrapping from 0xFFFF to 0x0000. The extend bit keeps its value.
- R10: The clear strobe sets the accumulator to 0 without touching the extend bit. If several accumulator strobes are raised together, clear takes precedence over increment, and increment over every load-type strobe.
- R11: The extend-clear strobe forces the extend bit to 0 and the extend-complement strobe inverts it; neither changes the accumulator. An extend-bit update from ADD or a rotate overrides the clear strobe when it wins the accumulator, and the clear strobe overrides the complement strobe.
- R12: With no strobe raised, the accumulator and the extend bit hold their values.
- R13: The flags track the registers in the same cycle. Zero is 1 exactly when the accumulator is 0. Sign equals accumulator bit 15. Extend-zero is 1 exactly when the extend bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_in | input | 16 | Operand word |
| inp_in | input | 8 | Input byte |
| op_and | input | 1 | AND with operand |
| op_add | input | 1 | Add operand, carry to extend bit |
| op_ldr | input | 1 | Load operand |
| op_ldi | input | 1 | Load input byte into low bits |
| op_cmp | input | 1 | Complement accumulator |
| op_cir | input | 1 | Rotate right through extend bit |
| op_cil | input | 1 | Rotate left through extend bit |
| op_inc | input | 1 | Increment accumulator |
| op_clr | input | 1 | Clear accumulator |
| op_cle | input | 1 | Clear extend bit |
| op_cme | input | 1 | Complement extend bit |
| acc_out | output | 16 | Accumulator value |
| e_out | output | 1 | Extend bit |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_neg | output | 1 | Accumulator bit 15 |
| e_zero | output | 1 | Extend bit is zero |

## Verification
All of the block's state is visible at its ports, so a wrong accumulator or extend value shows up one cycle after the strobe that produced it. A fault in a carry chain or a rotate neighbour is caught as soon as the operand pattern reaches that bit. A wrong control, such as a load taken on an increment or a lost extend update, corrupts the value seen in that same next cycle. Either error then carries into every later result. The bench therefore uses carries that run the full chain, rotates of single set bits, and strobe collisions, and compares the outputs after every edge.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dr_in,
  input  logic [BW-1:0] inp_in,
  input  logic         op_and,
  input  logic         op_add,
  input  logic         op_ldr,
  input  logic         op_ldi,
  input  logic         op_cmp,
  input  logic         op_cir,
  input  logic         op_cil,
  input  logic         op_inc,
  input  logic         op_clr,
  input  logic         op_cle,
  input  logic         op_cme,
  output logic [W-1:0] acc_out,
  output logic         e_out,
  output logic         acc_zero,
  output logic         acc_neg,
  output logic         e_zero
);
  localparam int TOP = W - 1;

  logic [W-1:0] ac, nx, sum;
  logic [W:0]   cy;
  logic         e, e_src, e_from_ld;
  logic         ld, inr, clr;

  assign ld  = op_and | op_add | op_ldr | op_ldi | op_cmp | op_cir | op_cil;
  assign inr = op_inc;
  assign clr = op_clr;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic rb, lb, ib;
    assign sum[i]  = ac[i] ^ dr_in[i] ^ cy[i];
    assign cy[i+1] = (ac[i] & dr_in[i]) | (cy[i] & (ac[i] ^ dr_in[i]));
    if (i == TOP) begin : g_hi
      assign rb = e;
    end else begin : g_rn
      assign rb = ac[i+1];
    end
    if (i == 0) begin : g_lo
      assign lb = e;
    end else begin : g_ln
      assign lb = ac[i-1];
    end
    if (i < BW) begin : g_in
      assign ib = inp_in[i];
    end else begin : g_keep
      assign ib = ac[i];
    end
    assign nx[i] = op_and ? (ac[i] & dr_in[i]) :
                   op_add ? sum[i] :
                   op_ldr ? dr_in[i] :
                   op_ldi ? ib :
                   op_cmp ? ~ac[i] :
                   op_cir ? rb : lb;
  end

  assign e_from_ld = ~clr & ~inr & (op_add | op_cir | op_cil);
  assign e_src     = op_add ? cy[W] : (op_cir ? ac[0] : ac[TOP]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ac <= '0;
    else if (clr)  ac <= '0;
    else if (inr)  ac <= ac + 1'b1;
    else if (ld)   ac <= nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         e <= 1'b0;
    else if (e_from_ld) e <= e_src;
    else if (op_cle)    e <= 1'b0;
    else if (op_cme)    e <= ~e;
  end

  assign acc_out  = ac;
  assign e_out    = e;
  assign acc_zero = (ac == '0);
  assign acc_neg  = ac[TOP];
  assign e_zero   = ~e;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_and,
  input logic         op_add,
  input logic         op_ldr,
  input logic         op_ldi,
  input logic         op_cmp,
  input logic         op_cir,
  input logic         op_cil,
  input logic         op_inc,
  input logic         op_clr,
  input logic         op_cle,
  input logic         op_cme,
  input logic [W-1:0] acc_out,
  input logic         e_out
);
  logic [10:0] ops;
  assign ops = {op_and, op_add, op_ldr, op_ldi, op_cmp, op_cir, op_cil,
                op_inc, op_clr, op_cle, op_cme};

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    op_clr |=> acc_out == '0); // R10
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_inc && !op_clr) |=> (acc_out == W'($past(acc_out) + 1'b1)) && (e_out == $past(e_out))); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ops == '0) |=> $stable(acc_out) && $stable(e_out)); // R12
  AST_LDI_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ldi && $countones(ops) == 1) |=> acc_out[W-1:BW] == $past(acc_out[W-1:BW])); // R5
  AST_CIR_E: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cir && $countones(ops) == 1) |=> e_out == $past(acc_out[0])); // R7
  AST_CIL_E: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cil && $countones(ops) == 1) |=> e_out == $past(acc_out[W-1])); // R8
  AST_E_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cle && $countones(ops) == 1) |=> !e_out && $stable(acc_out)); // R11
endmodule

bind acc_alu acc_alu_chk #(.W(W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_and(op_and), .op_add(op_add), .op_ldr(op_ldr),
  .op_ldi(op_ldi), .op_cmp(op_cmp), .op_cir(op_cir), .op_cil(op_cil),
  .op_inc(op_inc), .op_clr(op_clr), .op_cle(op_cle), .op_cme(op_cme),
  .acc_out(acc_out), .e_out(e_out)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  localparam int AND = 10, ADD = 9, LDR = 8, LDI = 7, CMP = 6, CIR = 5,
                 CIL = 4, INC = 3, CLR = 2, CLE = 1, CME = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] dr = '0;
  logic [7:0]  inp = '0;
  logic [10:0] ops = '0;
  logic [15:0] acc;
  logic e, zf, nf, ezf;

  logic [15:0] m_ac = '0;
  logic        m_e = 1'b0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .dr_in(dr), .inp_in(inp),
    .op_and(ops[AND]), .op_add(ops[ADD]), .op_ldr(ops[LDR]), .op_ldi(ops[LDI]),
    .op_cmp(ops[CMP]), .op_cir(ops[CIR]), .op_cil(ops[CIL]), .op_inc(ops[INC]),
    .op_clr(ops[CLR]), .op_cle(ops[CLE]), .op_cme(ops[CME]),
    .acc_out(acc), .e_out(e), .acc_zero(zf), .acc_neg(nf), .e_zero(ezf)
  );

  function automatic string tag_of(logic [10:0] o);
    if (o[CLR]) return "R10";
    if (o[INC]) return "R9";
    if (o[CLE] || o[CME]) return "R11";
    if (o[AND]) return "R2";
    if (o[ADD]) return "R3";
    if (o[LDR]) return "R4";
    if (o[LDI]) return "R5";
    if (o[CMP]) return "R6";
    if (o[CIR]) return "R7";
    if (o[CIL]) return "R8";
    return "R12";
  endfunction

  task automatic check(string tag);
    total++;
    if (acc !== m_ac || e !== m_e) begin
      bad++;
      $display("FAIL %s: acc=%h e=%b expected acc=%h e=%b", tag, acc, e, m_ac, m_e);
    end
    total++;
    if (zf !== (m_ac == 16'h0) || nf !== m_ac[15] || ezf !== !m_e) begin
      bad++;
      $display("FAIL R13: flags z=%b n=%b ez=%b expected z=%b n=%b ez=%b",
               zf, nf, ezf, m_ac == 16'h0, m_ac[15], !m_e);
    end
  endtask

  task automatic step(logic [10:0] o, logic [15:0] d, logic [7:0] b);
    logic [16:0] s;
    logic [15:0] old = m_ac;
    logic        oe = m_e;
    bit          e_by_op = 0;
    ops = o; dr = d; inp = b;
    if (o[CLR]) m_ac = 16'h0;
    else if (o[INC]) m_ac = old + 16'h1;
    else if (o[AND]) m_ac = old & d;
    else if (o[ADD]) begin
      s = {1'b0, old} + {1'b0, d};
      m_ac = s[15:0]; m_e = s[16]; e_by_op = 1;
    end
    else if (o[LDR]) m_ac = d;
    else if (o[LDI]) m_ac = {old[15:8], b};
    else if (o[CMP]) m_ac = ~old;
    else if (o[CIR]) begin m_ac = {oe, old[15:1]}; m_e = old[0]; e_by_op = 1; end
    else if (o[CIL]) begin m_ac = {old[14:0], oe}; m_e = old[15]; e_by_op = 1; end
    if (!e_by_op) begin
      if (o[CLE]) m_e = 1'b0;
      else if (o[CME]) m_e = ~oe;
    end
    @(negedge clk);
    check(tag_of(o));
  endtask

  function automatic logic [10:0] bit_of(int k);
    return 11'(1) << k;
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: acc=%h expected completion", acc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    step(bit_of(LDR), 16'h8001, 8'h00);           // R4, sign flag R13
    step(bit_of(CIR), 16'h0000, 8'h00);           // R7 bit0 to E
    step(bit_of(CIR), 16'h0000, 8'h00);           // R7 E into bit15
    step(bit_of(CIL), 16'h0000, 8'h00);           // R8
    step(bit_of(CIL), 16'h0000, 8'h00);           // R8
    step(bit_of(CLE), 16'h0000, 8'h00);           // R11
    step(bit_of(LDR), 16'hFFFF, 8'h00);
    step(bit_of(ADD), 16'h0001, 8'h00);           // R3 full carry chain, zero flag
    step(bit_of(CME), 16'h0000, 8'h00);           // R11
    step(bit_of(CMP), 16'h0000, 8'h00);           // R6
    step(bit_of(INC), 16'h1234, 8'h55);           // R9 wrap
    step(bit_of(LDR), 16'hA5C3, 8'h00);
    step(bit_of(LDI), 16'h0000, 8'h7E);           // R5 upper kept
    step(bit_of(AND), 16'h0FF0, 8'h00);           // R2
    step(11'h000, 16'hFFFF, 8'hFF);               // R12
    step(bit_of(CLR) | bit_of(INC), 16'h0, 8'h0); // R10 precedence
    step(bit_of(INC) | bit_of(LDR), 16'hBEEF, 8'h0); // R10 inc over load
    step(bit_of(ADD) | bit_of(CLE), 16'hFFFF, 8'h0); // R11 add carry wins
    step(bit_of(CLE) | bit_of(CME), 16'h0, 8'h0);    // R11 clear over complement
    step(bit_of(CLR) | bit_of(CIR), 16'h0, 8'h0);    // R10 clear over rotate
    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom_range(0, 11));
      logic [10:0] o = (k == 11) ? 11'h000 : bit_of(k);
      step(o, 16'($urandom), 8'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule